// File: doc/BRIEF.md
# Masked-Write GPIO Port Register File

This block is a 32-pin general-purpose I/O port with a small word-addressed register interface. For each pin it keeps a direction bit and an output latch bit. It drives a pad output-enable vector and a pad output-data vector, and it samples a pad input vector through a two-stage synchroniser.

Software never has to read, modify and write a shared register. Direction bits change only through two strobes: one register sets direction bits and the other clears them. The output latch changes only through two half-port registers. In each of these, the upper 16 data bits choose which pins change and the lower 16 data bits give their new values.

The latch keeps its value while a pin is an input. Software can therefore load the value a pin will drive and then turn on its driver.

Top module: `mpgpio_port`

## Requirements
- R1: While `rst_n` is low and after its release, every direction bit is 0 (all pins are inputs) and every output latch bit is 0. So `pad_oe` and `pad_out` are all zeros until the first write.
- R2: A write to offset 0x00 sets the direction bit of every pin whose data bit is 1. Pins whose data bit is 0 keep their direction. A read of 0x00 returns zero.
- R3: A write to offset 0x04 clears the direction bit of every pin whose data bit is 1, and leaves the others unchanged. A read of 0x04 returns the 32-bit direction vector, with bit n for pin n and 1 meaning output.
- R4: A write to offset 0x08 updates the latch of pins 0..15. For pin n, data bit n+16 enables the change and data bit n is the new value. A read of 0x08 returns the latch of pins 0..15 in bits 15:0, with zeros above.
- R5: A write to offset 0x0C updates the latch of pins 16..31 in the same way. Pin 16+n uses enable bit n+16 and value bit n. A read of 0x0C returns the latch of pins 16..31 in bits 15:0, with zeros above.
- R6: A read of offset 0x10 returns the pad inputs. A change on `pad_in` becomes visible after exactly two rising clock edges. Writes to 0x10 change nothing.
- R7: The output latch keeps its value whatever the direction bits do. `pad_out` always shows the latch, and the latch changes only on writes to 0x08 or 0x0C.
- R8: Reads of any other offset return zero, and writes to any other offset change neither direction nor latch.
- R9: `pad_oe` equals the direction register with no delay. A write takes effect on `pad_oe` and `pad_out` in the cycle after the clock edge that accepts it.
- R10: `bus_rdata` is zero unless `bus_valid` is high and `bus_write` is low. A read never changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_oe | output | 32 | Pad output enables, 1 = drive |
| pad_out | output | 32 | Pad output data (latch contents) |

## Verification
A wrong direction bit appears directly on `pad_oe` in the cycle after the write that caused it. Because `pad_oe` is compared after every bus operation, such an error is seen within one access.

A latch error appears the same way on `pad_out`, and also in the half-port readback. The readback matters because it is where a latch bit that should have been held while its pin was an input can be observed.

A wrong number of synchroniser stages shows as the new input level arriving one edge early or one edge late. Directed reads at one and at two edges after a pad change detect this.

// File: rtl/mpgpio_pkg.sv
`timescale 1ns/1ps
package mpgpio_pkg;

  localparam logic [31:0] OFS_DIR_SET = 32'h00;
  localparam logic [31:0] OFS_DIR_CLR = 32'h04;
  localparam logic [31:0] OFS_OUT_LO  = 32'h08;
  localparam logic [31:0] OFS_OUT_HI  = 32'h0C;
  localparam logic [31:0] OFS_IN_LVL  = 32'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR_SET,
    SEL_DIR_CLR,
    SEL_OUT_LO,
    SEL_OUT_HI,
    SEL_IN_LVL
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_DIR_SET: s = SEL_DIR_SET;
      OFS_DIR_CLR: s = SEL_DIR_CLR;
      OFS_OUT_LO:  s = SEL_OUT_LO;
      OFS_OUT_HI:  s = SEL_OUT_HI;
      OFS_IN_LVL:  s = SEL_IN_LVL;
      default:     s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mpgpio_dir_reg.sv
`timescale 1ns/1ps
module mpgpio_dir_reg #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [NPINS-1:0] bits,
  output logic [NPINS-1:0] dir_q
);

  logic [NPINS-1:0] dir_d;
  logic             dir_ce;

  // Next state: set then clear, only bits written as 1 are touched.
  always_comb begin
    dir_d = dir_q;
    if (set_en) dir_d = dir_d | bits;
    if (clr_en) dir_d = dir_d & ~bits;
  end

  assign dir_ce = set_en | clr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_ce) begin
      dir_q <= dir_d;
    end
  end

endmodule

// File: rtl/mpgpio_out_half.sv
`timescale 1ns/1ps
module mpgpio_out_half #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [HALF_W-1:0] mask,
  input  logic [HALF_W-1:0] value,
  output logic [HALF_W-1:0] latch_q
);

  logic [HALF_W-1:0] latch_d;

  // Per-bit merge: masked bits take the new value, others hold.
  always_comb begin
    latch_d = (latch_q & ~mask) | (value & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (wr_en) begin
      latch_q <= latch_d;
    end
  end

endmodule

// File: rtl/mpgpio_in_sync.sv
`timescale 1ns/1ps
module mpgpio_in_sync #(
  parameter int NPINS  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] async_in,
  output logic [NPINS-1:0] sync_out
);

  logic [NPINS-1:0] stage_q [STAGES];
  logic [NPINS-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = async_in;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/mpgpio_port.sv
`timescale 1ns/1ps
module mpgpio_port #(
  parameter int NPINS       = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out
);
  import mpgpio_pkg::*;

  localparam int HALF_W = NPINS / 2;
  localparam int NHALF  = 2;

  reg_sel_e         sel;
  logic             wr_acc;
  logic             rd_acc;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] in_sync;
  logic [NHALF-1:0] wr_half;

  assign sel    = decode_ofs(32'(bus_addr));
  assign wr_acc = bus_valid & bus_write;
  assign rd_acc = bus_valid & ~bus_write;

  assign wr_half[0] = wr_acc & (sel == SEL_OUT_LO);
  assign wr_half[1] = wr_acc & (sel == SEL_OUT_HI);

  mpgpio_dir_reg #(.NPINS(NPINS)) u_dir (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (wr_acc & (sel == SEL_DIR_SET)),
    .clr_en (wr_acc & (sel == SEL_DIR_CLR)),
    .bits   (bus_wdata[NPINS-1:0]),
    .dir_q  (dir_q)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    mpgpio_out_half #(.HALF_W(HALF_W)) u_half (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_half[h]),
      .mask    (bus_wdata[2*HALF_W-1:HALF_W]),
      .value   (bus_wdata[HALF_W-1:0]),
      .latch_q (out_q[h*HALF_W +: HALF_W])
    );
  end

  mpgpio_in_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (in_sync)
  );

  // Read mux: zero unless a read of a readable offset.
  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (sel)
        SEL_DIR_CLR: bus_rdata = DATA_W'(dir_q);
        SEL_OUT_LO:  bus_rdata = DATA_W'(out_q[HALF_W-1:0]);
        SEL_OUT_HI:  bus_rdata = DATA_W'(out_q[NPINS-1:HALF_W]);
        SEL_IN_LVL:  bus_rdata = DATA_W'(in_sync);
        default:     bus_rdata = '0;
      endcase
    end
  end

  assign pad_oe  = dir_q;
  assign pad_out = out_q;

endmodule

// File: rtl/mpgpio_port_chk.sv
`timescale 1ns/1ps
module mpgpio_port_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_out
);
  localparam int H = NPINS / 2;

  logic       w_set, w_clr, w_lo, w_hi, r_in, r_dir;
  logic [1:0] warm_q;

  assign w_set = bus_valid && bus_write && (bus_addr == ADDR_W'(8'h00));
  assign w_clr = bus_valid && bus_write && (bus_addr == ADDR_W'(8'h04));
  assign w_lo  = bus_valid && bus_write && (bus_addr == ADDR_W'(8'h08));
  assign w_hi  = bus_valid && bus_write && (bus_addr == ADDR_W'(8'h0C));
  assign r_in  = bus_valid && !bus_write && (bus_addr == ADDR_W'(8'h10));
  assign r_dir = bus_valid && !bus_write && (bus_addr == ADDR_W'(8'h04));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_dir_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    w_set |=> ((pad_oe & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  p_dir_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> ((pad_oe & $past(bus_wdata[NPINS-1:0])) == '0));

  p_dir_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    r_dir |-> (bus_rdata == DATA_W'(pad_oe)));

  p_out_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    w_lo |=> ((((pad_out[H-1:0] ^ $past(bus_wdata[H-1:0])) & $past(bus_wdata[2*H-1:H])) == '0)
          && (((pad_out[H-1:0] ^ $past(pad_out[H-1:0])) & ~$past(bus_wdata[2*H-1:H])) == '0)));

  p_out_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    w_hi |=> ((((pad_out[NPINS-1:H] ^ $past(bus_wdata[H-1:0])) & $past(bus_wdata[2*H-1:H])) == '0)
          && (((pad_out[NPINS-1:H] ^ $past(pad_out[NPINS-1:H])) & ~$past(bus_wdata[2*H-1:H])) == '0)));

  p_in_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_in && (warm_q >= 2'd2)) |-> (bus_rdata == DATA_W'($past(pad_in, 2))));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_lo || w_hi) |=> $stable(pad_out));

  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_set || w_clr) |=> $stable(pad_oe));

  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |-> (bus_rdata == '0));

endmodule

bind mpgpio_port mpgpio_port_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/mpgpio_port_tb.sv
`timescale 1ns/1ps
module mpgpio_port_tb_top;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_oe;
  logic [31:0] pad_out;

  int compared;
  int mismatched;
  logic [31:0] m_dir;
  logic [31:0] m_out;

  mpgpio_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] f_merge(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic void f_apply(input logic [7:0] a, input logic [31:0] w);
    case (a)
      8'h00: m_dir = m_dir | w;
      8'h04: m_dir = m_dir & ~w;
      8'h08: m_out[15:0]  = f_merge(m_out[15:0], w);
      8'h0C: m_out[31:16] = f_merge(m_out[31:16], w);
      default: ;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] w);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = w;
    #1 check("R10 rdata on write", bus_rdata, 32'h0);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    f_apply(a, w);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_wdata = $urandom;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic check_pads(input string req);
    #1;
    check({req, " pad_oe"}, pad_oe, m_dir);
    check({req, " pad_out"}, pad_out, m_out);
  endtask

  task automatic check_readback(input string req);
    logic [31:0] d;
    rd(8'h04, d); check({req, " R3 dir readback"}, d, m_dir);
    rd(8'h08, d); check({req, " R4 lo readback"}, d, {16'h0, m_out[15:0]});
    rd(8'h0C, d); check({req, " R5 hi readback"}, d, {16'h0, m_out[31:16]});
  endtask

  function automatic logic [7:0] pick_addr(input int k);
    case (k)
      0: return 8'h00;
      1: return 8'h04;
      2: return 8'h08;
      3: return 8'h0C;
      4: return 8'h10;
      5: return 8'h14;
      6: return 8'h02;
      default: return 8'hFC;
    endcase
  endfunction

  logic run_done;

  initial begin
    run_done = 1'b0;
    #(4 * 200000);
    if (!run_done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] w;
    void'($urandom(32'h5EED_1234));
    compared = 0; mismatched = 0;
    m_dir = '0; m_out = '0;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = 32'h0;
    repeat (3) @(negedge clk);
    check("R1 reset pad_oe", pad_oe, 32'h0);
    check("R1 reset pad_out", pad_out, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_pads("R1 after release");
    check_readback("R1");
    rd(8'h00, d); check("R2 read of set offset", d, 32'h0);

    // R2 / R3: set and clear only touch written ones.
    wr(8'h00, 32'hF0F0_00FF); check_pads("R2 set");
    wr(8'h00, 32'h0000_0F00); check_pads("R2 set keeps others");
    wr(8'h04, 32'h8000_0001); check_pads("R3 clear");
    check_readback("R3");

    // R9: oe visible in the cycle after the accepting edge.
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0001_0000;
    #1 check("R9 oe before edge", pad_oe, m_dir);
    @(negedge clk);
    bus_valid = 1'b0;
    f_apply(8'h00, 32'h0001_0000);
    check("R9 oe after edge", pad_oe, m_dir);

    // R4 / R5: masked half writes.
    wr(8'h08, 32'hFFFF_A5A5); check_pads("R4 full mask");
    wr(8'h08, 32'h00F0_0000); check_pads("R4 partial mask clears");
    wr(8'h08, 32'h0000_FFFF); check_pads("R4 zero mask no change");
    wr(8'h0C, 32'h8001_FFFF); check_pads("R5 edge bits");
    wr(8'h0C, 32'h0F00_0300); check_pads("R5 partial");
    check_readback("R4 R5");

    // R7: latch held while pins are inputs, then driven.
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_1234);
    wr(8'h0C, 32'hFFFF_8765);
    check_pads("R7 latch loaded while inputs");
    wr(8'h00, 32'hFFFF_FFFF);
    check_pads("R7 latch unchanged by direction");
    check("R7 out after enable", pad_out, 32'h8765_1234);

    // R8 / R6: writes to unmapped and input offsets ignored.
    wr(8'h14, 32'hFFFF_FFFF); check_pads("R8 unmapped write");
    wr(8'h10, 32'hFFFF_0000); check_pads("R6 input write ignored");
    check_readback("R8");
    rd(8'h14, d); check("R8 unmapped read", d, 32'h0);
    rd(8'hFC, d); check("R8 unmapped read top", d, 32'h0);

    // R6: two-edge input latency.
    pad_in = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    rd(8'h10, d); check("R6 settled", d, 32'hDEAD_BEEF);
    @(negedge clk);
    pad_in = 32'h1357_9BDF;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h10;
    @(negedge clk); #1 check("R6 one edge old", bus_rdata, 32'hDEAD_BEEF);
    @(negedge clk); #1 check("R6 two edges new", bus_rdata, 32'h1357_9BDF);
    bus_valid = 1'b0;
    #1 check("R10 idle rdata", bus_rdata, 32'h0);

    // Random mix.
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      a = pick_addr($urandom_range(0, 7));
      w = $urandom;
      if ($urandom_range(0, 3) == 0) begin
        rd(a, d);
        case (a)
          8'h04: check("R3 random read", d, m_dir);
          8'h08: check("R4 random read", d, {16'h0, m_out[15:0]});
          8'h0C: check("R5 random read", d, {16'h0, m_out[31:16]});
          8'h10: check("R6 random read", d, pad_in);
          default: check("R8 random read", d, 32'h0);
        endcase
      end else begin
        wr(a, w);
      end
      check_pads("R9 random");
    end

    run_done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule